// File: doc/BRIEF.md
# Clock Recovery Retry Monitor

This block sits beside a link-training sequencer and judges, after every failed clock-recovery attempt, whether training should stop retrying at the current settings and fall back. Each attempt is reported with a one-cycle strobe. The strobe carries the swing levels the lanes were driven with and the levels the sink has just asked for, each a 2-bit level per lane for four lanes, plus the number of lanes in use.

Three independent triggers can cause a fallback. The first is a cap on the total number of attempts. The second is a cap on consecutive attempts in which the sink asked for the swing it already had. The third is every enabled lane being pinned at the highest swing level with no change requested. When a trigger fires, the block raises a sticky fallback flag with a reason code and resets its counters. The sequencer releases the flag with a clear pulse, which it also issues whenever clock recovery succeeds or training restarts.

Top module: `cr_retry_monitor`

## Requirements
- R1: After reset, fallback_o is 0 and reason_o is 0 (none), and both attempt counters start from zero.
- R2: Each swing bus holds one 2-bit level per lane, lane k in bits [2k+1:2k], with level 3 the highest. lane_mode_i selects the enabled lanes: 0 means lane 0 only, 1 means lanes 0 and 1, and 2 or 3 means all four lanes.
- R3: Counting from reset, clear or the last fallback, the 10th accepted attempt raises fallback with reason 1 (total limit), whatever swing levels are given.
- R4: An attempt whose new request equals the previous levels on all enabled lanes increments the repeat counter. When the counter reaches 5, fallback is raised with reason 3 (repeated request). From a cleared state, this happens on the 5th consecutive identical attempt.
- R5: An attempt whose request differs on any enabled lane sets the repeat counter to 1. Four further identical attempts then raise reason 3.
- R6: An identical attempt in which every enabled lane is at level 3 in both the previous and the new levels raises fallback with reason 2 (maximum swing) on that attempt.
- R7: Disabled lanes take no part in either the equality test or the maximum-swing test.
- R8: When triggers coincide, reason 1 wins over reason 2, and reason 2 wins over reason 3.
- R9: fallback_o and reason_o change in the cycle after the triggering strobe. They then hold, ignoring further strobes, until clear_i.
- R10: clear_i zeroes the flag, the reason and both counters, and wins over a strobe in the same cycle. That strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Clear flag and counters (success, restart, fallback taken) |
| attempt_i | input | 1 | One-cycle strobe: a clock-recovery attempt failed |
| prev_swing_i | input | 8 | Swing levels in use for that attempt, 2 bits per lane |
| new_swing_i | input | 8 | Swing levels requested by the sink, 2 bits per lane |
| lane_mode_i | input | 2 | Enabled lane set: 0 = one, 1 = two, 2/3 = four |
| fallback_o | output | 1 | Fallback required, held until clear |
| reason_o | output | 2 | 0 none, 1 total limit, 2 maximum swing, 3 repeated request |

## Verification
On every cycle, the assertions check the following: both counters stay below their limits; the flag holds until a clear; a clear always empties the flag and the reason; the reason is nonzero exactly when the flag is set; and the flag never rises without a strobe on the previous edge. Whether the correct trigger fires, and on exactly which attempt, can only be shown by the bench's scenarios. These cover the 10th-attempt cap, the 5th identical request, the restart of the repeat count at 1, lanes masked by lane mode, priority between coinciding triggers, and a clear that coincides with a strobe.

// File: rtl/cr_mon_pkg.sv
package cr_mon_pkg;
  localparam int unsigned SWING_W   = 2;
  localparam int unsigned SWING_MAX = (1 << SWING_W) - 1;

  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_TOTAL  = 2'd1,
    RSN_MAXSW  = 2'd2,
    RSN_REPEAT = 2'd3
  } reason_e;
endpackage

// File: rtl/cr_swing_compare.sv
module cr_swing_compare
  import cr_mon_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*SWING_W-1:0] prev_i,
  input  logic [LANES*SWING_W-1:0] new_i,
  input  logic [1:0]               lane_mode_i,
  output logic                     same_o,
  output logic                     all_max_o
);
  localparam int unsigned CNT_W = $clog2(LANES) + 3;

  logic [CNT_W-1:0] n_en;
  logic [LANES-1:0] lane_eq, lane_max;

  assign n_en = CNT_W'(1) << lane_mode_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic               en;
    logic [SWING_W-1:0] p, n;
    assign en = CNT_W'(k) < n_en;
    assign p  = prev_i[k*SWING_W +: SWING_W];
    assign n  = new_i[k*SWING_W +: SWING_W];
    // disabled lanes always agree
    assign lane_eq[k]  = !en || (p == n);
    assign lane_max[k] = !en || ((p == SWING_W'(SWING_MAX)) && (n == SWING_W'(SWING_MAX)));
  end

  assign same_o    = &lane_eq;
  assign all_max_o = &lane_max;

  always_comb begin
    if (all_max_o && !same_o) begin
      AST_MAX_IMPLIES_SAME: assert (0) else $error("max without equality"); // R6
    end
  end
endmodule

// File: rtl/cr_attempt_counters.sv
module cr_attempt_counters #(
  parameter int unsigned TOTAL_LIMIT = 10,
  parameter int unsigned SAME_LIMIT  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic same_i,
  output logic total_hit_o,
  output logic repeat_hit_o
);
  localparam int unsigned TW = $clog2(TOTAL_LIMIT + 1);
  localparam int unsigned SW = $clog2(SAME_LIMIT + 1);

  logic [TW-1:0] total_q;
  logic [SW-1:0] same_q;

  assign total_hit_o  = (32'(total_q) + 32'd1) >= TOTAL_LIMIT;
  assign repeat_hit_o = same_i && ((32'(same_q) + 32'd1) >= SAME_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      same_q  <= '0;
    end else if (clr_i) begin
      total_q <= '0;
      same_q  <= '0;
    end else if (step_i) begin
      total_q <= total_q + TW'(1);
      same_q  <= same_i ? same_q + SW'(1) : SW'(1);
    end
  end

  AST_TOTAL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(total_q) < TOTAL_LIMIT) else $error("total counter overflow"); // R3
  AST_SAME_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(same_q) < SAME_LIMIT) else $error("repeat counter overflow"); // R4
  AST_SAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && !same_i |=> same_q == SW'(1)) else $error("repeat restart"); // R5
endmodule

// File: rtl/cr_fallback_arbiter.sv
module cr_fallback_arbiter
  import cr_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic       total_hit_i,
  input  logic       max_hit_i,
  input  logic       repeat_hit_i,
  output logic       fire_o,
  output logic       fallback_o,
  output logic [1:0] reason_o
);
  reason_e reason_d, reason_q;
  logic    flag_q;

  always_comb begin
    if (total_hit_i)       reason_d = RSN_TOTAL;
    else if (max_hit_i)    reason_d = RSN_MAXSW;
    else if (repeat_hit_i) reason_d = RSN_REPEAT;
    else                   reason_d = RSN_NONE;
  end

  assign fire_o = step_i && (reason_d != RSN_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else if (clear_i) begin
      flag_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else if (fire_o) begin
      flag_q   <= 1'b1;
      reason_q <= reason_d;
    end
  end

  assign fallback_o = flag_q;
  assign reason_o   = reason_q;

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o && !clear_i |=> fallback_o && $stable(reason_o)) else $error("flag dropped"); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !fallback_o && reason_o == 2'd0) else $error("clear ignored"); // R10
  AST_REASON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o == (reason_o != 2'd0)) else $error("reason mismatch"); // R1
  AST_TOTAL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && total_hit_i && !clear_i |=> reason_o == 2'd1) else $error("priority"); // R8
endmodule

// File: rtl/cr_retry_monitor.sv
module cr_retry_monitor
  import cr_mon_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned TOTAL_LIMIT = 10,
  parameter int unsigned SAME_LIMIT  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     attempt_i,
  input  logic [LANES*SWING_W-1:0] prev_swing_i,
  input  logic [LANES*SWING_W-1:0] new_swing_i,
  input  logic [1:0]               lane_mode_i,
  output logic                     fallback_o,
  output logic [1:0]               reason_o
);
  logic same, all_max, step, fire;
  logic total_hit, repeat_hit;

  // strobes while flagged or clearing are dropped
  assign step = attempt_i && !fallback_o && !clear_i;

  cr_swing_compare #(.LANES(LANES)) i_cmp (
    .prev_i      (prev_swing_i),
    .new_i       (new_swing_i),
    .lane_mode_i (lane_mode_i),
    .same_o      (same),
    .all_max_o   (all_max)
  );

  cr_attempt_counters #(.TOTAL_LIMIT(TOTAL_LIMIT), .SAME_LIMIT(SAME_LIMIT)) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clear_i || fire),
    .step_i       (step),
    .same_i       (same),
    .total_hit_o  (total_hit),
    .repeat_hit_o (repeat_hit)
  );

  cr_fallback_arbiter i_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .step_i       (step),
    .total_hit_i  (total_hit),
    .max_hit_i    (same && all_max),
    .repeat_hit_i (repeat_hit),
    .fire_o       (fire),
    .fallback_o   (fallback_o),
    .reason_o     (reason_o)
  );

  AST_RISE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fallback_o) |-> $past(attempt_i) && !$past(clear_i)) else $error("spurious fallback"); // R9
endmodule

// File: tb/test_cr_retry_monitor.sv
`timescale 1ns/1ps
module test_cr_retry_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       attempt_i = 1'b0;
  logic [7:0] prev_swing_i = '0;
  logic [7:0] new_swing_i = '0;
  logic [1:0] lane_mode_i = 2'd2;
  logic       fallback_o;
  logic [1:0] reason_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk_i = ~clk_i;

  cr_retry_monitor i_cr_retry_monitor (
    .clk_i, .rst_ni, .clear_i, .attempt_i, .prev_swing_i,
    .new_swing_i, .lane_mode_i, .fallback_o, .reason_o
  );

  task automatic check(input string req, input logic ef, input logic [1:0] er);
    n_tests++;
    if (fallback_o !== ef || reason_o !== er) begin
      n_fail++;
      $display("FAIL %s: flag=%0b reason=%0d expected flag=%0b reason=%0d",
               req, fallback_o, reason_o, ef, er);
    end
  endtask

  // strobe at negedge, result visible at next negedge
  task automatic attempt(input logic [7:0] p, input logic [7:0] n, input logic [1:0] m);
    prev_swing_i = p; new_swing_i = n; lane_mode_i = m; attempt_i = 1'b1;
    @(negedge clk_i);
    attempt_i = 1'b0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0, 2'd0);
  endtask

  task automatic t_total();
    do_clear();
    for (int i = 0; i < 9; i++) attempt(8'h00, 8'h55, 2'd2);
    check("R3 nine attempts", 1'b0, 2'd0);
    attempt(8'h00, 8'hAA, 2'd2);
    check("R3 tenth attempt", 1'b1, 2'd1);
  endtask

  task automatic t_repeat();
    do_clear();
    check("R10 clear", 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) attempt(8'h55, 8'h55, 2'd2);
    check("R4 four identical", 1'b0, 2'd0);
    attempt(8'h55, 8'h55, 2'd2);
    check("R4 fifth identical", 1'b1, 2'd3);
  endtask

  task automatic t_restart();
    do_clear();
    for (int i = 0; i < 3; i++) attempt(8'h11, 8'h11, 2'd2);
    attempt(8'h11, 8'h22, 2'd2);
    for (int i = 0; i < 3; i++) attempt(8'h22, 8'h22, 2'd2);
    check("R5 three after differ", 1'b0, 2'd0);
    attempt(8'h22, 8'h22, 2'd2);
    check("R5 fourth after differ", 1'b1, 2'd3);
  endtask

  task automatic t_max();
    do_clear();
    attempt(8'h3F, 8'h3F, 2'd2);
    check("R6 lane3 not max", 1'b0, 2'd0);
    attempt(8'hFF, 8'hFF, 2'd3);
    check("R6 four lanes max", 1'b1, 2'd2);
  endtask

  task automatic t_masked();
    do_clear();
    attempt(8'hA3, 8'h53, 2'd0);
    check("R7 one lane max, others differ", 1'b1, 2'd2);
    do_clear();
    attempt(8'h0F, 8'hCF, 2'd1);
    check("R7 two lanes max, upper differ", 1'b1, 2'd2);
    do_clear();
    attempt(8'h0F, 8'h0F, 2'd0);
    check("R2 one lane at level 3 only", 1'b1, 2'd2);
    do_clear();
    attempt(8'h3C, 8'h3C, 2'd1);
    check("R2 lane0 below max in two-lane mode", 1'b0, 2'd0);
  endtask

  task automatic t_priority();
    do_clear();
    for (int i = 0; i < 9; i++) attempt(8'h00, 8'h01, 2'd2);
    attempt(8'hFF, 8'hFF, 2'd2);
    check("R8 total over max", 1'b1, 2'd1);
    do_clear();
    for (int i = 0; i < 4; i++) attempt(8'h00, 8'h00, 2'd2);
    attempt(8'hFF, 8'hFF, 2'd2);
    check("R8 max over repeat", 1'b1, 2'd2);
  endtask

  task automatic t_hold();
    do_clear();
    attempt(8'hFF, 8'hFF, 2'd2);
    for (int i = 0; i < 12; i++) attempt(8'h00, 8'h40, 2'd2);
    check("R9 held through strobes", 1'b1, 2'd2);
    // clear and strobe together: strobe must not count
    do_clear();
    for (int i = 0; i < 4; i++) attempt(8'h66, 8'h66, 2'd2);
    clear_i = 1'b1;
    attempt(8'h66, 8'h66, 2'd2);
    clear_i = 1'b0;
    check("R10 clear beats strobe", 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) attempt(8'h66, 8'h66, 2'd2);
    check("R10 counters restarted", 1'b0, 2'd0);
    attempt(8'h66, 8'h66, 2'd2);
    check("R10 fifth after clear", 1'b1, 2'd3);
  endtask

  task automatic t_timing();
    do_clear();
    for (int i = 0; i < 4; i++) attempt(8'h77, 8'h77, 2'd2);
    prev_swing_i = 8'h77; new_swing_i = 8'h77; attempt_i = 1'b1;
    @(posedge clk_i);
    #1;
    check("R9 flag after strobe edge", 1'b1, 2'd3);
    @(negedge clk_i);
    attempt_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_total();
    t_repeat();
    t_restart();
    t_max();
    t_masked();
    t_priority();
    t_hold();
    t_timing();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule